// File: doc/BRIEF.md
# Flash Embedded-Operation Status Word Generator

This block builds the status word that a flash device returns on its data bus when the host polls it while an internal program or erase algorithm is running. It tracks which kind of operation is in flight (word program, sector erase or whole-chip erase), which sectors take part in an erase, whether the erase is suspended and whether the algorithm has reported a time-limit failure. It also keeps the two toggle bits. These bits change on every status read, not on clock edges. Each read strobe registers a fresh 8-bit status word together with a flag that tells the bus logic whether to drive that word or ordinary array data.

In the status word, bit 7 is the polling bit, bit 6 is the main toggle bit, bit 5 is the time-limit failure flag, bit 3 is the sector-erase start indicator and bit 2 is the erasing-sector toggle bit. The other bits read 0. A sector erase opens an acceptance window of `WIN_CYC` clock cycles. Further sector-add commands are taken only while the window is open, and each accepted one restarts it. The ready output goes low while an algorithm actively runs. The sequencer that starts, ends and fails operations sits outside this block. It drives the event inputs as single-cycle pulses.

Top module: `emb_status_gen`

## Requirements
- R1: After reset, `ry_by_o` is 1 and both `stat_sel_o` and `stat_o` are 0.
- R2: `ry_by_o` goes to 0 in the cycle after an accepted `op_start` and returns to 1 in the cycle after `op_done`.
- R3: Status word bit 6 inverts on every status read while an operation runs unsuspended, and it reads 1 on the first read after a start. `stat_o` and `stat_sel_o` change only on cycles with `rd_stb`.
- R4: Bit 7 is the complement of `prog_d7` during a program and 0 during an active erase. It is 1 when a read hits an erase-suspended sector.
- R5: Bit 2 inverts only on reads whose sector belongs to the current erase set. Other reads leave it unchanged, and it stays 0 throughout a program.
- R6: Bit 3 reads 0 during a sector erase until `WIN_CYC` cycles pass without an accepted add, and 1 afterwards. It reads 1 from the start of a chip erase and 0 during a program.
- R7: `sect_add` adds its sector to the erase set only while the window is open. After the window closes, an add has no effect, and a read of that sector does not invert bit 2.
- R8: A chip erase selects every sector whose `sect_prot` bit is 0. A read of a protected sector does not invert bit 2.
- R9: `susp_req` is accepted only during a sector erase whose window has closed. While suspended, `ry_by_o` is 1, reads outside the erase set return `stat_sel_o`=0, and bit 6 holds its value.
- R10: After `op_fail`, bit 5 reads 1 and bit 6 keeps inverting on each read. `op_done` clears bit 5.
- R11: After `op_done`, a read returns `stat_sel_o`=0 and `stat_o`=0.
- R12: `op_start` is ignored while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_stb | input | 1 | One-cycle pulse per host read access (output-enable or chip-enable cycle) |
| rd_sect | input | SECT_W | Sector index of the read address |
| op_start | input | 1 | Operation start event |
| op_kind | input | 2 | Kind for `op_start`: 1 program, 2 sector erase, 3 chip erase |
| op_sect | input | SECT_W | Target sector for a sector erase start or add |
| prog_d7 | input | 1 | Bit 7 of the word being programmed |
| sect_add | input | 1 | Additional sector-erase command |
| op_done | input | 1 | Algorithm finished, or reset command after a failure |
| op_fail | input | 1 | Algorithm exceeded its time limit |
| susp_req | input | 1 | Erase suspend command |
| resume_req | input | 1 | Erase resume command |
| sect_prot | input | NSECT | Per-sector protection flags |
| stat_o | output | 8 | Registered status word |
| stat_sel_o | output | 1 | 1 when the last read returns the status word rather than array data |
| ry_by_o | output | 1 | Ready (1) / busy (0) |

## Verification
A program is polled with both values of the data bit, so that the polling bit can be told apart from a constant. Reads are also spread out in time, which shows that the toggle bits follow reads rather than clock cycles. A sector erase is polled alternately inside and outside its erase set, before and after the window closes, with a late add and an early suspend mixed in. Together these separate the two toggle bits and the window indicator from one another. Suspend, resume, failure and a chip erase with one protected sector then cover the paths where bit 6 freezes, the status is withheld, or protection removes a sector from the set.

// File: rtl/emb_status_pkg.sv
package emb_status_pkg;

  typedef enum logic [1:0] {
    OPK_NONE   = 2'd0,
    OPK_PROG   = 2'd1,
    OPK_SERASE = 2'd2,
    OPK_CHIP   = 2'd3
  } opk_e;

  // toggle bank lanes
  localparam int unsigned TG_MAIN  = 0;
  localparam int unsigned TG_ERASE = 1;
  localparam int unsigned TG_N     = 2;

  function automatic logic is_erase(opk_e k);
    return (k == OPK_SERASE) || (k == OPK_CHIP);
  endfunction

  // assemble the polled status word from tracked state and toggle values
  function automatic logic [7:0] compose(opk_e kind, logic susp, logic fail,
                                         logic win_open, logic pd7,
                                         logic tg_main, logic tg_erase);
    logic [7:0] w;
    w = '0;
    case (kind)
      OPK_PROG:              w[7] = ~pd7;
      OPK_SERASE, OPK_CHIP:  w[7] = susp;
      default:               w[7] = 1'b0;
    endcase
    w[6] = tg_main;
    w[5] = fail;
    w[3] = (kind == OPK_CHIP) || ((kind == OPK_SERASE) && !win_open);
    w[2] = tg_erase;
    return w;
  endfunction

endpackage

// File: rtl/emb_op_tracker.sv
module emb_op_tracker
  import emb_status_pkg::*;
#(
  parameter int NSECT   = 16,
  parameter int WIN_CYC = 2500,
  parameter int SECT_W  = $clog2(NSECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [SECT_W-1:0] op_sect,
  input  logic              prog_d7,
  input  logic              sect_add,
  input  logic              op_done,
  input  logic              op_fail,
  input  logic              susp_req,
  input  logic              resume_req,
  input  logic [NSECT-1:0]  sect_prot,
  output opk_e              kind_o,
  output logic [NSECT-1:0]  eset_o,
  output logic              susp_o,
  output logic              fail_o,
  output logic              pd7_o,
  output logic              win_open_o,
  output logic              start_acc_o,
  output logic              add_acc_o,
  output logic              susp_acc_o
);

  localparam int CNT_W = $clog2(WIN_CYC + 1);

  opk_e             kind_q;
  logic [NSECT-1:0] eset_q;
  logic             susp_q, fail_q, pd7_q;
  logic [CNT_W-1:0] win_q;
  opk_e             req_kind;
  logic [NSECT-1:0] tgt;
  logic             resume_acc;

  assign req_kind   = opk_e'(op_kind);
  assign tgt        = (NSECT'(1) << op_sect) & ~sect_prot;
  assign win_open_o = (win_q != '0);

  assign start_acc_o = op_start && !op_done && (kind_q == OPK_NONE) && (req_kind != OPK_NONE);
  assign add_acc_o   = sect_add && !op_done && (kind_q == OPK_SERASE) && win_open_o && !susp_q;
  assign susp_acc_o  = susp_req && !op_done && (kind_q == OPK_SERASE) && !win_open_o
                       && !susp_q && !fail_q;
  assign resume_acc  = resume_req && !op_done && susp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= OPK_NONE;
      eset_q <= '0;
      susp_q <= 1'b0;
      fail_q <= 1'b0;
      pd7_q  <= 1'b0;
      win_q  <= '0;
    end else if (op_done) begin
      kind_q <= OPK_NONE;
      eset_q <= '0;
      susp_q <= 1'b0;
      fail_q <= 1'b0;
      pd7_q  <= 1'b0;
      win_q  <= '0;
    end else if (start_acc_o) begin
      kind_q <= req_kind;
      pd7_q  <= prog_d7;
      susp_q <= 1'b0;
      fail_q <= 1'b0;
      case (req_kind)
        OPK_SERASE: begin eset_q <= tgt;        win_q <= CNT_W'(WIN_CYC); end
        OPK_CHIP:   begin eset_q <= ~sect_prot; win_q <= '0;              end
        default:    begin eset_q <= '0;         win_q <= '0;              end
      endcase
    end else begin
      if (add_acc_o) begin
        eset_q <= eset_q | tgt;
        win_q  <= CNT_W'(WIN_CYC);
      end else if (win_q != '0) begin
        win_q <= win_q - 1'b1;
      end
      if (susp_acc_o)      susp_q <= 1'b1;
      else if (resume_acc) susp_q <= 1'b0;
      if (op_fail && (kind_q != OPK_NONE)) fail_q <= 1'b1;
    end
  end

  assign kind_o = kind_q;
  assign eset_o = eset_q;
  assign susp_o = susp_q;
  assign fail_o = fail_q;
  assign pd7_o  = pd7_q;

endmodule

// File: rtl/emb_toggle_bank.sv
module emb_toggle_bank #(
  parameter int NBIT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [NBIT-1:0] adv,
  output logic [NBIT-1:0] nxt_o,
  output logic [NBIT-1:0] state_o
);

  for (genvar g = 0; g < NBIT; g++) begin : g_lane
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (clr)    q <= 1'b0;
      else if (adv[g]) q <= ~q;
    end
    assign nxt_o[g]   = adv[g] ? ~q : q;
    assign state_o[g] = q;
  end

endmodule

// File: rtl/emb_status_gen.sv
module emb_status_gen
  import emb_status_pkg::*;
#(
  parameter int NSECT   = 16,
  parameter int WIN_CYC = 2500,
  parameter int SECT_W  = $clog2(NSECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic [SECT_W-1:0] rd_sect,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [SECT_W-1:0] op_sect,
  input  logic              prog_d7,
  input  logic              sect_add,
  input  logic              op_done,
  input  logic              op_fail,
  input  logic              susp_req,
  input  logic              resume_req,
  input  logic [NSECT-1:0]  sect_prot,
  output logic [7:0]        stat_o,
  output logic              stat_sel_o,
  output logic              ry_by_o
);

  opk_e             kind;
  logic [NSECT-1:0] eset;
  logic             susp, fail, pd7, win_open;
  logic             start_acc, add_acc, susp_acc;
  logic             run, hit, stat_en;
  logic [TG_N-1:0]  tg_adv, tg_nxt, tg_q;
  logic [7:0]       stat_d;
  logic [7:0]       stat_q;
  logic             sel_q;

  emb_op_tracker #(.NSECT(NSECT), .WIN_CYC(WIN_CYC), .SECT_W(SECT_W)) i_trk (
    .clk(clk), .rst_n(rst_n),
    .op_start(op_start), .op_kind(op_kind), .op_sect(op_sect), .prog_d7(prog_d7),
    .sect_add(sect_add), .op_done(op_done), .op_fail(op_fail),
    .susp_req(susp_req), .resume_req(resume_req), .sect_prot(sect_prot),
    .kind_o(kind), .eset_o(eset), .susp_o(susp), .fail_o(fail), .pd7_o(pd7),
    .win_open_o(win_open), .start_acc_o(start_acc), .add_acc_o(add_acc),
    .susp_acc_o(susp_acc)
  );

  assign run     = (kind != OPK_NONE) && !susp;
  assign hit     = ({1'b0, rd_sect} < (SECT_W+1)'(NSECT)) ? eset[rd_sect] : 1'b0;
  assign stat_en = rd_stb && (kind != OPK_NONE) && (!susp || hit);

  assign tg_adv[TG_MAIN]  = rd_stb && run;
  assign tg_adv[TG_ERASE] = rd_stb && hit && is_erase(kind);

  emb_toggle_bank #(.NBIT(TG_N)) i_tog (
    .clk(clk), .rst_n(rst_n), .clr(start_acc),
    .adv(tg_adv), .nxt_o(tg_nxt), .state_o(tg_q)
  );

  assign stat_d = stat_en ? compose(kind, susp, fail, win_open, pd7,
                                    tg_nxt[TG_MAIN], tg_nxt[TG_ERASE]) : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 8'h00;
      sel_q  <= 1'b0;
    end else if (rd_stb) begin
      stat_q <= stat_d;
      sel_q  <= stat_en;
    end
  end

  assign stat_o     = stat_q;
  assign stat_sel_o = sel_q;
  assign ry_by_o    = !run;

endmodule

// File: rtl/emb_status_chk.sv
module emb_status_chk
  import emb_status_pkg::*;
#(
  parameter int TG_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_stb,
  input logic            op_done,
  input logic [7:0]      stat_o,
  input logic            stat_sel_o,
  input logic            ry_by_o,
  input opk_e            kind,
  input logic            susp,
  input logic            fail,
  input logic            win_open,
  input logic            start_acc,
  input logic            run,
  input logic            hit,
  input logic [TG_W-1:0] tg_q
);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> !ry_by_o);

  p_done_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> ry_by_o);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ($stable(stat_o) && $stable(stat_sel_o)));

  p_main_tog_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && run) |=> (stat_o[6] == tg_q[0]));

  p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (kind == OPK_SERASE) && win_open && !susp) |=> !stat_o[3]);

  p_fail_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && fail && run) |=> stat_o[5]);

  p_susp_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    susp |-> ry_by_o);

  p_susp_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    susp |-> !win_open);

  p_susp_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && susp && !hit) |=> !stat_sel_o);

endmodule

bind emb_status_gen emb_status_chk #(.TG_W(emb_status_pkg::TG_N)) i_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .op_done(op_done),
  .stat_o(stat_o), .stat_sel_o(stat_sel_o), .ry_by_o(ry_by_o),
  .kind(kind), .susp(susp), .fail(fail), .win_open(win_open),
  .start_acc(start_acc), .run(run), .hit(hit), .tg_q(tg_q)
);

// File: tb/test_emb_status_gen.sv
module test_emb_status_gen;

  localparam int NSECT = 16;
  localparam int SW    = 4;
  localparam int WIN   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_stb = 0, op_start = 0, prog_d7 = 0, sect_add = 0, op_done = 0;
  logic op_fail = 0, susp_req = 0, resume_req = 0;
  logic [SW-1:0] rd_sect = '0, op_sect = '0;
  logic [1:0] op_kind = '0;
  logic [NSECT-1:0] sect_prot = '0;
  logic [7:0] stat_o;
  logic stat_sel_o, ry_by_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  emb_status_gen #(.NSECT(NSECT), .WIN_CYC(WIN)) i_emb_status_gen (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_sect(rd_sect),
    .op_start(op_start), .op_kind(op_kind), .op_sect(op_sect), .prog_d7(prog_d7),
    .sect_add(sect_add), .op_done(op_done), .op_fail(op_fail),
    .susp_req(susp_req), .resume_req(resume_req), .sect_prot(sect_prot),
    .stat_o(stat_o), .stat_sel_o(stat_sel_o), .ry_by_o(ry_by_o)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input int s);
    @(negedge clk); rd_sect = SW'(s); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic start(input int kind, input int s, input logic d7);
    @(negedge clk); op_start = 1'b1; op_kind = 2'(kind); op_sect = SW'(s); prog_d7 = d7;
    @(negedge clk); op_start = 1'b0;
  endtask

  task automatic pulse_done();  @(negedge clk); op_done = 1;    @(negedge clk); op_done = 0;    endtask
  task automatic pulse_fail();  @(negedge clk); op_fail = 1;    @(negedge clk); op_fail = 0;    endtask
  task automatic pulse_susp();  @(negedge clk); susp_req = 1;   @(negedge clk); susp_req = 0;   endtask
  task automatic pulse_res();   @(negedge clk); resume_req = 1; @(negedge clk); resume_req = 0; endtask
  task automatic pulse_add(input int s);
    @(negedge clk); sect_add = 1; op_sect = SW'(s);
    @(negedge clk); sect_add = 0;
  endtask

  task automatic t_reset();
    chk("R1 ry_by", 8'(ry_by_o), 8'h01);
    chk("R1 sel", 8'(stat_sel_o), 8'h00);
    chk("R1 stat", stat_o, 8'h00);
  endtask

  task automatic t_program();
    start(1, 3, 1'b1);
    chk("R2 busy after start", 8'(ry_by_o), 8'h00);
    rd(0); chk("R4 R3 prog first read", stat_o, 8'h40);
    chk("R3 sel", 8'(stat_sel_o), 8'h01);
    rd(0); chk("R3 prog second read", stat_o, 8'h00);
    repeat (5) @(negedge clk);
    chk("R3 no change without read", stat_o, 8'h00);
    start(3, 0, 1'b0);
    rd(7); chk("R12 start ignored, R5 dq2 stays 0", stat_o, 8'h40);
    pulse_done();
    chk("R2 ready after done", 8'(ry_by_o), 8'h01);
    rd(0); chk("R11 sel after done", 8'(stat_sel_o), 8'h00);
    chk("R11 stat after done", stat_o, 8'h00);
    start(1, 5, 1'b0);
    rd(5); chk("R4 prog d7=0", stat_o, 8'hC0);
    pulse_done();
  endtask

  task automatic t_sector_erase();
    start(2, 2, 1'b0);
    rd(2); chk("R6 R5 erase in-set window open", stat_o, 8'h44);
    pulse_add(6);
    rd(9); chk("R5 out-of-set read", stat_o, 8'h04);
    repeat (WIN + 3) @(negedge clk);
    rd(6); chk("R7 R6 added sector after window", stat_o, 8'h48);
    pulse_add(9);
    rd(9); chk("R7 late add ignored", stat_o, 8'h08);
    pulse_susp();
    chk("R9 ready while suspended", 8'(ry_by_o), 8'h01);
    rd(9); chk("R9 miss while suspended", 8'(stat_sel_o), 8'h00);
    rd(2); chk("R9 R4 suspended hit", stat_o, 8'h8C);
    rd(6); chk("R9 dq6 held", stat_o, 8'h88);
    pulse_res();
    chk("R2 busy after resume", 8'(ry_by_o), 8'h00);
    rd(2); chk("R3 resumed", stat_o, 8'h4C);
    pulse_fail();
    rd(2); chk("R10 fail first", stat_o, 8'h28);
    rd(2); chk("R10 fail still toggling", stat_o, 8'h6C);
    pulse_done();
    rd(2); chk("R10 R11 cleared", stat_o, 8'h00);
  endtask

  task automatic t_early_suspend();
    start(2, 1, 1'b0);
    pulse_susp();
    chk("R9 suspend in window ignored", 8'(ry_by_o), 8'h00);
    rd(1); chk("R9 R4 not suspended", stat_o, 8'h44);
    pulse_done();
  endtask

  task automatic t_chip();
    @(negedge clk); sect_prot = 16'h0010;
    start(3, 0, 1'b0);
    rd(0); chk("R6 R8 chip first", stat_o, 8'h4C);
    rd(4); chk("R8 protected sector", stat_o, 8'h0C);
    rd(15); chk("R8 unprotected sector", stat_o, 8'h48);
    pulse_susp();
    chk("R9 chip suspend ignored", 8'(ry_by_o), 8'h00);
    pulse_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_program();
    t_sector_erase();
    t_early_suspend();
    t_chip();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule